// File: doc/BRIEF.md
# Input Transition Capture Channel

This block is a single timer channel that watches one asynchronous input pin. It latches the value of a free-running timebase when the pin makes a selected transition. It can also latch only after a programmed number of such transitions. Each latch is a capture event. A capture event raises an interrupt request for one cycle. If software allows it, the same event also raises link requests to a block of neighbouring channels and pulses a flag-increment strobe. That strobe carries a byte address toward a small shared parameter memory. The memory does the increment, so another channel can use that byte as a flag.

Software sets the channel up through a four-word register interface. Writing the control word re-initializes the channel. After a capture, the channel runs on in continuous operation, or it halts in single-shot operation until the next control write.

The controller has four states:
- `S_IDLE`: edge selection is disabled.
- `S_ARMED`: counting qualifying transitions.
- `S_FIRE`: the one cycle in which the interrupt, links and flag strobe are presented.
- `S_HALT`: single-shot finished.

The transitions are:
- Reset goes to `S_IDLE`.
- Any control write goes to `S_IDLE` if its edge field is 0, and to `S_ARMED` otherwise. A control write takes priority over every other transition.
- `S_ARMED` goes to `S_FIRE` on the last counted transition.
- `S_FIRE` goes to `S_HALT` in single-shot operation, and to `S_ARMED` otherwise.
- `S_IDLE` and `S_HALT` hold until a control write.

Top module: `itc_capture_channel`

## Requirements
- R1: The pin passes through two synchronizer flops. A capture latches the timebase value present at the third rising clock edge at which the new pin level is sampled. `irq_o` is high in the clock cycle after that edge.
- R2: The edge field is control bits [1:0]. Value 1 qualifies rising transitions only, 2 qualifies falling only, and 3 qualifies both. Transitions that do not qualify cause no capture.
- R3: With count register (address 1) value N ≥ 1, a capture happens on every Nth qualifying transition. A value of 0 acts as 1. The remaining count reloads after each capture and on each control write.
- R4: Every capture produces exactly one single-cycle pulse on `irq_o`.
- R5: When control bit 2 is 0 (continuous), capturing goes on indefinitely. When it is 1 (single-shot), the channel ignores all transitions after its first capture, and `cap_o` holds its value, until the control word is written again.
- R6: Control bit 3 enables links. The link register (address 2) holds the start channel in bits [3:0] and the count in bits [7:4]. During `irq_o`, `link_o` has bits (start+i) mod 16 set for i < min(count, 8). A count of 0 sets no bits. With links disabled, `link_o` stays 0.
- R7: Control bit 4 enables the flag strobe. When enabled, `flag_inc_o` is high exactly during `irq_o`, and `flag_addr_o` carries the value written to address 3.
- R8: After reset the channel is in `S_IDLE`, and `cap_o`, `irq_o`, `link_o` and `flag_inc_o` are all 0.
- R9: When the edge field is 0, no transition causes a capture or an interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tbase_i | input | TB_W (16) | Free-running timebase value |
| pin_i | input | 1 | Asynchronous input pin |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 2 | Register select: 0 control, 1 count, 2 link, 3 flag address |
| cfg_wdata_i | input | 16 | Register write data |
| cap_o | output | TB_W (16) | Last captured timebase value |
| irq_o | output | 1 | Capture interrupt pulse |
| link_o | output | NCH (16) | Link request vector, one bit per channel |
| flag_inc_o | output | 1 | Flag-increment strobe |
| flag_addr_o | output | FA_W (6) | Byte address of the flag |

## Verification
Each edge selection is tried against both rising and falling pin transitions, which separates the rising, falling and both-edge codes from one another and from the disabled code. Transition counts from 0 to 4 are run for two full rounds, so both the Nth-transition rule and the reload after each capture are exercised. Link generation is swept over every start channel and every count from 0 to 9, which covers wrap-around, the empty block and clamping at eight. Single-shot and continuous operation are told apart by applying further transitions after the first capture, and then re-arming the channel with a control write.

// File: rtl/itc_pkg.sv
package itc_pkg;
    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_ARMED = 2'd1,
        S_FIRE  = 2'd2,
        S_HALT  = 2'd3
    } state_t;

    typedef enum logic [1:0] {
        EDGE_OFF  = 2'd0,
        EDGE_RISE = 2'd1,
        EDGE_FALL = 2'd2,
        EDGE_ANY  = 2'd3
    } edge_t;

    typedef struct packed {
        logic  flag_en;
        logic  link_en;
        logic  single;
        edge_t edge_sel;
    } ctrl_t;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_MAXC = 2'd1;
    localparam logic [1:0] ADDR_LINK = 2'd2;
    localparam logic [1:0] ADDR_FLAG = 2'd3;
endpackage

// File: rtl/itc_edge_detect.sv
module itc_edge_detect
    import itc_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  pin_i,
    input  edge_t edge_sel_i,
    output logic  hit_o
);
    logic sync1_q, sync2_q, prev_q;
    logic rise, fall;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync1_q <= 1'b0;
            sync2_q <= 1'b0;
            prev_q  <= 1'b0;
        end else begin
            sync1_q <= pin_i;
            sync2_q <= sync1_q;
            prev_q  <= sync2_q;
        end
    end

    assign rise = sync2_q & ~prev_q;
    assign fall = ~sync2_q & prev_q;

    always_comb begin
        unique case (edge_sel_i)
            EDGE_RISE: hit_o = rise;
            EDGE_FALL: hit_o = fall;
            EDGE_ANY:  hit_o = rise | fall;
            default:   hit_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/itc_link_gen.sv
module itc_link_gen #(
    parameter int NCH  = 16,
    parameter int MAXL = 8,
    parameter int SW   = $clog2(NCH),
    parameter int CNTW = 4
) (
    input  logic [SW-1:0]   start_i,
    input  logic [CNTW-1:0] count_i,
    output logic [NCH-1:0]  vec_o
);
    int eff;

    always_comb begin
        eff = (int'(count_i) > MAXL) ? MAXL : int'(count_i);
    end

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        always_comb begin
            int off;
            off = (g - int'(start_i) + NCH) % NCH;
            vec_o[g] = (off < eff);
        end
    end
endmodule

// File: rtl/itc_capture_channel.sv
module itc_capture_channel
    import itc_pkg::*;
#(
    parameter int TB_W = 16,
    parameter int NCH  = 16,
    parameter int MAXL = 8,
    parameter int CW   = 8,
    parameter int FA_W = 6,
    parameter int DW   = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [TB_W-1:0] tbase_i,
    input  logic            pin_i,
    input  logic            cfg_we_i,
    input  logic [1:0]      cfg_addr_i,
    input  logic [DW-1:0]   cfg_wdata_i,
    output logic [TB_W-1:0] cap_o,
    output logic            irq_o,
    output logic [NCH-1:0]  link_o,
    output logic            flag_inc_o,
    output logic [FA_W-1:0] flag_addr_o
);
    localparam int SW   = $clog2(NCH);
    localparam int LCW  = 4;
    localparam int CTLW = $bits(ctrl_t);

    state_t          state_q, state_d;
    ctrl_t           ctrl_q, ctrl_new;
    logic [CW-1:0]   maxc_q, maxc_eff, rem_q;
    logic [SW-1:0]   lstart_q;
    logic [LCW-1:0]  lcount_q;
    logic [FA_W-1:0] faddr_q;
    logic [TB_W-1:0] cap_q;
    logic            hit, last_hit, ctrl_wr;
    logic [NCH-1:0]  link_vec;

    assign ctrl_new = ctrl_t'(cfg_wdata_i[CTLW-1:0]);
    assign ctrl_wr  = cfg_we_i && (cfg_addr_i == ADDR_CTRL);
    assign maxc_eff = (maxc_q == '0) ? CW'(1) : maxc_q;
    assign last_hit = hit && (rem_q <= CW'(1));

    itc_edge_detect u_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_i      (pin_i),
        .edge_sel_i (ctrl_q.edge_sel),
        .hit_o      (hit)
    );

    itc_link_gen #(.NCH(NCH), .MAXL(MAXL), .SW(SW), .CNTW(LCW)) u_link (
        .start_i (lstart_q),
        .count_i (lcount_q),
        .vec_o   (link_vec)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  state_d = S_IDLE;
            S_ARMED: if (last_hit) state_d = S_FIRE;
            S_FIRE:  state_d = ctrl_q.single ? S_HALT : S_ARMED;
            S_HALT:  state_d = S_HALT;
        endcase
        if (ctrl_wr)
            state_d = (ctrl_new.edge_sel == EDGE_OFF) ? S_IDLE : S_ARMED;
    end

    // state register and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= S_IDLE;
            ctrl_q   <= '0;
            maxc_q   <= CW'(1);
            rem_q    <= CW'(1);
            lstart_q <= '0;
            lcount_q <= '0;
            faddr_q  <= '0;
            cap_q    <= '0;
        end else begin
            state_q <= state_d;
            if (cfg_we_i) begin
                unique case (cfg_addr_i)
                    ADDR_CTRL: ctrl_q <= ctrl_new;
                    ADDR_MAXC: maxc_q <= cfg_wdata_i[CW-1:0];
                    ADDR_LINK: begin
                        lstart_q <= cfg_wdata_i[SW-1:0];
                        lcount_q <= cfg_wdata_i[SW+LCW-1:SW];
                    end
                    ADDR_FLAG: faddr_q <= cfg_wdata_i[FA_W-1:0];
                endcase
            end
            if (ctrl_wr)
                rem_q <= maxc_eff;
            else if (state_q == S_ARMED && hit)
                rem_q <= last_hit ? maxc_eff : rem_q - CW'(1);
            if (state_q == S_ARMED && last_hit && !ctrl_wr)
                cap_q <= tbase_i;
        end
    end

    // outputs decoded from state
    always_comb begin
        irq_o       = (state_q == S_FIRE);
        link_o      = (irq_o && ctrl_q.link_en) ? link_vec : '0;
        flag_inc_o  = irq_o && ctrl_q.flag_en;
        flag_addr_o = faddr_q;
        cap_o       = cap_q;
    end

    // R4: an interrupt never lasts two cycles
    p_irq_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o);

    // R5: a halted channel keeps its captured value until re-armed
    p_halt_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_HALT && !ctrl_wr) |=> (state_q == S_HALT && $stable(cap_o)));

    // R6: link block never exceeds the limit and only accompanies an interrupt
    p_link_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(link_o) <= MAXL);
    p_link_with_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (link_o != '0) |-> irq_o);

    // R7: flag strobe only accompanies an interrupt
    p_flag_with_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
        flag_inc_o |-> irq_o);

    // R9: an idle channel raises nothing
    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE) |=> !irq_o);
endmodule

// File: tb/tb_itc_capture_channel.sv
module tb_itc_capture_channel;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] tbase = '0;
    logic        pin = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_addr = '0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] cap;
    logic        irq;
    logic [15:0] link;
    logic        flag_inc;
    logic [5:0]  flag_addr;

    int errors = 0;
    int checks = 0;
    logic [15:0] last_cap = '0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always_ff @(posedge clk) tbase <= tbase + 16'd1;

    itc_capture_channel dut (
        .clk(clk), .rst_n(rst_n), .tbase_i(tbase), .pin_i(pin),
        .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata),
        .cap_o(cap), .irq_o(irq), .link_o(link),
        .flag_inc_o(flag_inc), .flag_addr_o(flag_addr)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        @(negedge clk);
    endtask

    // toggle pin at a negedge, sample in the interrupt cycle three negedges later
    task automatic toggle(input bit exp_fire, input string req);
        logic [15:0] t0;
        pin = ~pin;
        t0 = tbase;
        repeat (3) @(negedge clk);
        chk(irq == exp_fire, req, "irq", 32'(irq), 32'(exp_fire));
        if (exp_fire) begin
            chk(cap == 16'(t0 + 16'd2), req, "capture", 32'(cap), 32'(16'(t0 + 16'd2)));
            last_cap = cap;
        end
    endtask

    function automatic logic [15:0] exp_link(input int s, input int c);
        logic [15:0] v;
        int e;
        v = '0;
        e = (c > 8) ? 8 : c;
        for (int i = 0; i < e; i++) v[(s + i) % 16] = 1'b1;
        return v;
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        checks++; errors++;
        $display("FAIL watchdog: actual hang expected finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R8 reset state
        chk(cap == 0, "R8", "cap after reset", 32'(cap), 0);
        chk(irq == 0, "R8", "irq after reset", 32'(irq), 0);
        chk(link == 0, "R8", "link after reset", 32'(link), 0);
        chk(flag_inc == 0, "R8", "flag after reset", 32'(flag_inc), 0);

        // R9: disabled edge field
        toggle(1'b0, "R9");
        toggle(1'b0, "R9");

        // R1/R2: each edge selection against rise and fall
        for (int es = 0; es < 4; es++) begin
            wr(2'd0, 16'(es));
            for (int k = 0; k < 2; k++) begin
                bit rising;
                bit ef;
                rising = (pin == 1'b0);
                ef = (es == 3) || (es == 1 && rising) || (es == 2 && !rising);
                toggle(ef, (es == 0) ? "R9" : "R2 R1");
                @(negedge clk);
                chk(irq == 0, "R4", "irq drops", 32'(irq), 0);
            end
        end

        // R3: transition counts 0..4, two rounds each
        for (int n = 0; n < 5; n++) begin
            int eff;
            eff = (n == 0) ? 1 : n;
            wr(2'd1, 16'(n));
            wr(2'd0, 16'h0003);
            for (int r = 0; r < 2; r++)
                for (int k = 1; k <= eff; k++)
                    toggle(k == eff, "R3");
        end

        // R6/R7: link sweep, flag strobe
        wr(2'd1, 16'd1);
        wr(2'd3, 16'd45);
        wr(2'd0, 16'h001B);
        for (int s = 0; s < 16; s++)
            for (int c = 0; c < 10; c++) begin
                wr(2'd2, 16'((c << 4) | s));
                toggle(1'b1, "R6");
                chk(link == exp_link(s, c), "R6", "link vector", 32'(link), 32'(exp_link(s, c)));
                chk(flag_inc == 1'b1, "R7", "flag strobe", 32'(flag_inc), 1);
                chk(flag_addr == 6'd45, "R7", "flag address", 32'(flag_addr), 45);
            end
        // links and flag disabled
        wr(2'd2, 16'h0083);
        wr(2'd0, 16'h0003);
        toggle(1'b1, "R6");
        chk(link == 0, "R6", "link disabled", 32'(link), 0);
        chk(flag_inc == 0, "R7", "flag disabled", 32'(flag_inc), 0);

        // R5: single-shot
        wr(2'd0, 16'h0007);
        toggle(1'b1, "R5");
        for (int k = 0; k < 3; k++) begin
            toggle(1'b0, "R5");
            chk(cap == last_cap, "R5", "cap held", 32'(cap), 32'(last_cap));
        end
        wr(2'd0, 16'h0007);
        toggle(1'b1, "R5");
        // continuous keeps going
        wr(2'd0, 16'h0003);
        for (int k = 0; k < 4; k++) toggle(1'b1, "R5");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule